// File: doc/BRIEF.md
# DS3 Receive Alarm Interrupt Controller

This block sits beside a DS3 receive framer and turns alarm activity into one host interrupt. Once per received frame, the framer presents the two X bits together with a one-cycle frame strobe. From these the block keeps a far-end receive failure (FERF) state. It raises a change-of-state event both when that state is declared and when it is cleared.

Seven more receive conditions arrive as single-cycle event pulses from logic outside this block:

- CP-bit error
- loss of signal (LOS)
- alarm indication signal (AIS)
- idle
- AIC change
- out of frame (OOF)
- P-bit error

All eight sources share two registers on a small host read/write port. One is an enable register. The other is a status register that clears when it is read. A third, read-only location holds the live FERF state, so an interrupt handler can tell whether the alarm has just appeared or just gone away.

Top module: `ds3_rx_alarm_irq`

## Requirements
- R1: After reset the enable register, status register, FERF state and `irq` are all 0.
- R2: A frame strobe with both X bits equal to 0 declares FERF. The state is readable at address 0x11, bit 3, from the cycle after the strobe.
- R3: A frame strobe with X bits 01, 10 or 11 clears FERF. Clearing is also a change-of-state event.
- R4: The FERF state changes only on a frame strobe. A FERF event (status bit 3) is produced only when the new state differs from the stored state. X bits without a strobe, and repeated frames that keep the same state, have no effect.
- R5: Address 0x12 is the read/write enable register. A 1 in a bit enables that source and a 0 disables it.
- R6: Address 0x13 is the status register, and each source sets its own bit there:

  | Bit | Source |
  |-----|--------|
  | 7 | CP-bit error |
  | 6 | LOS |
  | 5 | AIS |
  | 4 | idle |
  | 3 | FERF change |
  | 2 | AIC |
  | 1 | OOF |
  | 0 | P-bit error |

  An enabled event sets its bit at the clock edge on which it occurs.
- R7: An event whose enable bit is 0 at that edge is dropped and never sets status.
- R8: A read of 0x13 returns the current status and clears it. If an enabled event arrives in the same cycle as that read, the read returns the old value and the new bit stays set afterwards.
- R9: `irq` is high exactly while some status bit and its enable bit are both 1. Clearing the enable hides a pending bit, and setting the enable again exposes it.
- R10: A write to address 0x11, to address 0x13 or to any unmapped address changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_strobe | input | 1 | One-cycle pulse per received frame |
| x_bits | input | 2 | The two X bits of the frame, valid with `frm_strobe` |
| evt_cpbit | input | 1 | CP-bit error event pulse |
| evt_los | input | 1 | LOS event pulse |
| evt_ais | input | 1 | AIS event pulse |
| evt_idle | input | 1 | Idle event pulse |
| evt_aic | input | 1 | AIC event pulse |
| evt_oof | input | 1 | OOF event pulse |
| evt_pbit | input | 1 | P-bit error event pulse |
| host_addr | input | 8 | Host register address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe; a read of the status register clears it at the edge |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data, valid while `host_rd` is high, 0 otherwise |
| irq | output | 1 | Active-high interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit address, the state, enable and status registers at 0x11, 0x12 and 0x13, two X bits and eight sources. With these defaults, every X-bit combination can be driven into the FERF detector, and each of the eight status bit positions can be tested one at a time. This also makes it possible to line up a host read with an event arrival on the same edge. A queue of expected read values is filled by the driver tasks and checked against `host_rdata` at every read strobe.

// File: rtl/rxa_pkg.sv
// Package: shared constants for the DS3 receive alarm interrupt controller.
// Assumes the source bit positions below are the status/enable layout seen by
// host software; any change here changes the register map.
package rxa_pkg;
    localparam int unsigned NUM_SRC   = 8;   // interrupt sources
    localparam int unsigned X_W       = 2;   // X bits per frame
    localparam int unsigned SRC_PBIT  = 0;
    localparam int unsigned SRC_OOF   = 1;
    localparam int unsigned SRC_AIC   = 2;
    localparam int unsigned SRC_FERF  = 3;
    localparam int unsigned SRC_IDLE  = 4;
    localparam int unsigned SRC_AIS   = 5;
    localparam int unsigned SRC_LOS   = 6;
    localparam int unsigned SRC_CPBIT = 7;
endpackage

// File: rtl/ferf_tracker.sv
// Module: ferf_tracker
// Keeps the far-end receive failure state from the X bits of each frame and
// emits a one-cycle change event whenever a frame flips that state.
// Assumes frm_strobe is a single-cycle pulse and x_bits is valid with it.
module ferf_tracker #(
    parameter int unsigned XW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frm_strobe,
    input  logic [XW-1:0] x_bits,
    output logic          ferf_state,
    output logic          ferf_chg
);
    logic alarm_now;

    // Purpose: a frame indicates the alarm when every X bit is zero.
    always_comb alarm_now = (x_bits == '0);

    // Purpose: a change event exists only on a strobe that alters the state.
    always_comb ferf_chg = frm_strobe && (alarm_now != ferf_state);

    // Purpose: the state register loads only on a frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)          ferf_state <= 1'b0;
        else if (frm_strobe) ferf_state <= alarm_now;
    end

    // R2: all-zero X bits on a strobe declare the alarm.
    p_declare_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_strobe && x_bits == '0) |=> ferf_state);
    // R3: any non-zero X pattern on a strobe clears it.
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_strobe && x_bits != '0) |=> !ferf_state);
    // R4: no strobe, no state movement.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_strobe |=> $stable(ferf_state));
endmodule

// File: rtl/irq_src_bank.sv
// Module: irq_src_bank
// Holds the enable and clear-on-read status bits for N interrupt sources and
// forms the interrupt request from pending, enabled bits.
// Assumes events are single-cycle pulses; an event is captured only if its
// enable bit is already 1 at that edge.
module irq_src_bank #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         en_wr,
    input  logic [N-1:0] en_wdata,
    input  logic         st_rd_clr,
    output logic [N-1:0] en_q,
    output logic [N-1:0] st_q,
    output logic         irq
);
    logic [N-1:0] st_nxt;
    logic [N-1:0] pend;

    // Per-source next status: old bits survive unless cleared by a read,
    // enabled events always land (so a same-cycle event outlives the read).
    for (genvar i = 0; i < N; i++) begin : g_src
        assign st_nxt[i] = (st_q[i] & ~st_rd_clr) | (evt[i] & en_q[i]);
        assign pend[i]   = st_q[i] & en_q[i];

        // R7: a disabled, idle bit cannot become set.
        p_drop_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_q[i] && !st_q[i]) |=> !st_q[i]);
        // R8: an enabled event is visible next cycle even across a read.
        p_event_sticks_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[i] && en_q[i]) |=> st_q[i]);
    end

    // Purpose: enable register, loaded by host writes.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= en_wdata;
    end

    // Purpose: status register, set by events and cleared by reads.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_nxt;
    end

    // Purpose: request while any enabled bit is pending.
    always_comb irq = |pend;

    // R8: a read with no concurrent enabled event empties the register.
    p_rdclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rd_clr && ((evt & en_q) == '0)) |=> (st_q == '0));
endmodule

// File: rtl/host_regs.sv
// Module: host_regs
// Decodes the host port: enable write strobe, status clear-on-read strobe and
// the read data mux. Read data is combinational and gated by the read strobe.
// Assumes host_rd and host_wr are not raised for the same address together.
module host_regs #(
    parameter int unsigned           ADDR_W     = 8,
    parameter int unsigned           DATA_W     = 8,
    parameter int unsigned           STATE_BIT  = 3,
    parameter logic [ADDR_W-1:0]     ADDR_STATE = 8'h11,
    parameter logic [ADDR_W-1:0]     ADDR_EN    = 8'h12,
    parameter logic [ADDR_W-1:0]     ADDR_STAT  = 8'h13
) (
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              ferf_state,
    input  logic [DATA_W-1:0] en_q,
    input  logic [DATA_W-1:0] st_q,
    output logic              en_wr,
    output logic              st_rd_clr,
    output logic [DATA_W-1:0] host_rdata
);
    logic [DATA_W-1:0] state_word;

    // Purpose: place the live alarm state at its bit in the state word.
    always_comb begin
        state_word            = '0;
        state_word[STATE_BIT] = ferf_state;
    end

    // Purpose: only the enable register accepts writes.
    always_comb en_wr = host_wr && (host_addr == ADDR_EN);

    // Purpose: a read of the status register clears it at the edge.
    always_comb st_rd_clr = host_rd && (host_addr == ADDR_STAT);

    // Purpose: read mux, zero outside a read or at unmapped addresses.
    always_comb begin
        host_rdata = '0;
        if (host_rd) begin
            if (host_addr == ADDR_STATE)     host_rdata = state_word;
            else if (host_addr == ADDR_EN)   host_rdata = en_q;
            else if (host_addr == ADDR_STAT) host_rdata = st_q;
        end
    end
endmodule

// File: rtl/ds3_rx_alarm_irq.sv
// Module: ds3_rx_alarm_irq (top)
// Collects the FERF change-of-state event and seven receive event pulses into
// an enable/status register pair on a host port and drives one interrupt.
// Assumes synchronous active-low reset and single-cycle event pulses.
module ds3_rx_alarm_irq #(
    parameter int unsigned       ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] ADDR_STATE = 8'h11,
    parameter logic [ADDR_W-1:0] ADDR_EN    = 8'h12,
    parameter logic [ADDR_W-1:0] ADDR_STAT  = 8'h13
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frm_strobe,
    input  logic [rxa_pkg::X_W-1:0]     x_bits,
    input  logic                        evt_cpbit,
    input  logic                        evt_los,
    input  logic                        evt_ais,
    input  logic                        evt_idle,
    input  logic                        evt_aic,
    input  logic                        evt_oof,
    input  logic                        evt_pbit,
    input  logic [ADDR_W-1:0]           host_addr,
    input  logic                        host_wr,
    input  logic                        host_rd,
    input  logic [rxa_pkg::NUM_SRC-1:0] host_wdata,
    output logic [rxa_pkg::NUM_SRC-1:0] host_rdata,
    output logic                        irq
);
    import rxa_pkg::*;

    logic               ferf_state;
    logic               ferf_chg;
    logic [NUM_SRC-1:0] evt_vec;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] st_q;
    logic               en_wr;
    logic               st_rd_clr;

    // Purpose: route each source to its register bit position.
    always_comb begin
        evt_vec            = '0;
        evt_vec[SRC_PBIT]  = evt_pbit;
        evt_vec[SRC_OOF]   = evt_oof;
        evt_vec[SRC_AIC]   = evt_aic;
        evt_vec[SRC_FERF]  = ferf_chg;
        evt_vec[SRC_IDLE]  = evt_idle;
        evt_vec[SRC_AIS]   = evt_ais;
        evt_vec[SRC_LOS]   = evt_los;
        evt_vec[SRC_CPBIT] = evt_cpbit;
    end

    ferf_tracker #(.XW(X_W)) u_ferf (
        .clk        (clk),
        .rst_n      (rst_n),
        .frm_strobe (frm_strobe),
        .x_bits     (x_bits),
        .ferf_state (ferf_state),
        .ferf_chg   (ferf_chg)
    );

    irq_src_bank #(.N(NUM_SRC)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt_vec),
        .en_wr     (en_wr),
        .en_wdata  (host_wdata),
        .st_rd_clr (st_rd_clr),
        .en_q      (en_q),
        .st_q      (st_q),
        .irq       (irq)
    );

    host_regs #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (NUM_SRC),
        .STATE_BIT  (SRC_FERF),
        .ADDR_STATE (ADDR_STATE),
        .ADDR_EN    (ADDR_EN),
        .ADDR_STAT  (ADDR_STAT)
    ) u_regs (
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .ferf_state (ferf_state),
        .en_q       (en_q),
        .st_q       (st_q),
        .en_wr      (en_wr),
        .st_rd_clr  (st_rd_clr),
        .host_rdata (host_rdata)
    );

    // R9: a new request needs a prior event or an enable write.
    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(evt_vec != '0) || $past(en_wr)));
    // R10: writes elsewhere than the enable register leave it unchanged.
    p_stray_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr != ADDR_EN) |=> $stable(en_q));
    // R1: the request is low in the first cycle after reset.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !irq);
endmodule

// File: tb/tb_ds3_rx_alarm_irq.sv
module tb_ds3_rx_alarm_irq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_strobe = 1'b0;
    logic [1:0] x_bits = 2'b11;
    logic       evt_cpbit = 0, evt_los = 0, evt_ais = 0, evt_idle = 0;
    logic       evt_aic = 0, evt_oof = 0, evt_pbit = 0;
    logic [7:0] host_addr = 8'h00;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       irq;

    int tests = 0;
    int fails = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ds3_rx_alarm_irq dut (
        .clk(clk), .rst_n(rst_n), .frm_strobe(frm_strobe), .x_bits(x_bits),
        .evt_cpbit(evt_cpbit), .evt_los(evt_los), .evt_ais(evt_ais),
        .evt_idle(evt_idle), .evt_aic(evt_aic), .evt_oof(evt_oof),
        .evt_pbit(evt_pbit), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq(irq)
    );

    task automatic check(logic [7:0] act, logic [7:0] exp, string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Monitor: every read strobe pops one expected value and compares.
    always @(negedge clk) begin
        if (host_rd) begin
            if (exp_q.size() == 0) check(host_rdata, 8'hxx, "scoreboard empty");
            else check(host_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic set_evt(logic [7:0] v);
        evt_pbit = v[0]; evt_oof = v[1]; evt_aic = v[2]; evt_idle = v[4];
        evt_ais = v[5]; evt_los = v[6]; evt_cpbit = v[7];
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic rd_evt(logic [7:0] a, logic [7:0] exp, logic [7:0] ev, string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        host_addr = a; host_rd = 1'b1; set_evt(ev);
        step();
        host_rd = 1'b0; set_evt(8'h00);
    endtask

    task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
        rd_evt(a, exp, 8'h00, tag);
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        step();
        host_wr = 1'b0;
    endtask

    task automatic frame(logic [1:0] x);
        x_bits = x; frm_strobe = 1'b1;
        step();
        frm_strobe = 1'b0;
    endtask

    task automatic pulse(logic [7:0] v);
        set_evt(v);
        step();
        set_evt(8'h00);
    endtask

    task automatic chk_irq(logic exp, string tag);
        check({7'b0, irq}, {7'b0, exp}, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk_irq(1'b0, "R1 irq after reset");
        rd(8'h12, 8'h00, "R1 enable reset");
        rd(8'h13, 8'h00, "R1 status reset");
        rd(8'h11, 8'h00, "R1 state reset");

        // R7 everything disabled: events and FERF declaration dropped
        pulse(8'hF7);
        frame(2'b00);
        rd(8'h13, 8'h00, "R7 disabled events dropped");
        rd(8'h11, 8'h08, "R2 FERF declared state");
        chk_irq(1'b0, "R7 no irq while disabled");

        // R5 enable register read/write
        wr(8'h12, 8'hFF);
        rd(8'h12, 8'hFF, "R5 enable all");
        wr(8'h12, 8'hA5);
        rd(8'h12, 8'hA5, "R5 enable pattern");

        // R10 stray writes
        wr(8'h11, 8'h00);
        wr(8'h13, 8'hFF);
        wr(8'h40, 8'h00);
        rd(8'h11, 8'h08, "R10 state read-only");
        rd(8'h13, 8'h00, "R10 status not writable");
        rd(8'h12, 8'hA5, "R10 enable untouched");

        // R4 no event without a change, no change without a strobe
        wr(8'h12, 8'hFF);
        frame(2'b00);
        rd(8'h13, 8'h00, "R4 repeat frame no event");
        x_bits = 2'b01;
        step();
        rd(8'h11, 8'h08, "R4 X bits without strobe");

        // R3 clearing is an event
        frame(2'b01);
        rd(8'h11, 8'h00, "R3 FERF cleared by 01");
        chk_irq(1'b1, "R9 irq on FERF clear");
        rd(8'h13, 8'h08, "R3 clear sets FERF status");
        rd(8'h13, 8'h00, "R8 read cleared status");
        chk_irq(1'b0, "R9 irq drops after read");

        // R2 declaration, then clear by 10, then no change on 11
        frame(2'b00);
        rd(8'h13, 8'h08, "R2 declare sets FERF status");
        frame(2'b10);
        rd(8'h11, 8'h00, "R3 FERF cleared by 10");
        rd(8'h13, 8'h08, "R3 clear by 10 event");
        frame(2'b11);
        rd(8'h13, 8'h00, "R4 11 after clear no event");

        // R6 bit mapping of the other seven sources
        for (int i = 0; i < 8; i++) begin
            if (i != 3) begin
                pulse(8'(1 << i));
                rd(8'h13, 8'(1 << i), $sformatf("R6 source bit %0d", i));
            end
        end

        // R9 enable masks a pending bit
        pulse(8'h40);
        chk_irq(1'b1, "R9 irq pending LOS");
        wr(8'h12, 8'h00);
        chk_irq(1'b0, "R9 irq masked");
        wr(8'h12, 8'hFF);
        chk_irq(1'b1, "R9 irq unmasked");
        rd(8'h13, 8'h40, "R9 pending LOS kept");
        chk_irq(1'b0, "R9 irq after read");

        // R7 partial enable
        wr(8'h12, 8'h01);
        pulse(8'h41);
        rd(8'h13, 8'h01, "R7 only enabled source latched");

        // R8 event during read
        wr(8'h12, 8'hFF);
        pulse(8'h02);
        rd_evt(8'h13, 8'h02, 8'h04, "R8 read returns old value");
        rd(8'h13, 8'h04, "R8 concurrent event kept");
        chk_irq(1'b0, "R8 irq clear at end");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule